// File: doc/BRIEF.md
# Capture DMA Instruction Sequencer

This block is a small programmable DMA engine. It moves captured 32-bit words from a data FIFO into system memory. It does not follow a fixed descriptor ring. It fetches a list of two-word instructions (a command word, then an address word) through a memory read port and executes them. It supports five operations:

- **Absolute write:** places data at the address given in the instruction.
- **Continued write:** places data at the address that follows the last one used.
- **Skip:** discards FIFO data.
- **Jump:** loads the program counter, so a program can loop.
- **Sync:** drains the FIFO until a word tagged with a chosen marker code has been consumed.

Each instruction carries a 4-bit clear mask and a 4-bit set mask for a progress nibble. Software reads the nibble from the top of the status word to see how far the program has advanced. Software loads a start address, sets both enable bits of the control register, and then handles interrupts. Interrupts come from instructions that carry an interrupt flag, from FIFO resynchronisation errors, and from undefined opcodes. Every status flag is sticky, is cleared by writing 1, and is gated by a mask register.

Top module: `capdma_seq`

## Requirements
- R1: After reset the status word reads 0, the control register is 0, `irq` is low, and no fetch, memory write or FIFO pop is issued.
- R2: When control bits 1:0 (register select 1) are both 1, the engine fetches the command word at the start address (select 0), then the address word at the next word address. The following instruction is fetched 8 bytes further on.
- R3: Opcode 0x1 (command bits 31:28) pops count/4 FIFO words, where count is command bits 11:0 in bytes. It writes them to consecutive word addresses, starting at the address word. Each write carries command bits 15:12 on `dmem_be`. A count below 4 completes at once without writing.
- R4: Opcode 0x5 writes the same way as opcode 0x1, but starts at the word after the last address written, and ignores its address word.
- R5: Opcode 0x2 pops count/4 FIFO words and issues no memory write.
- R6: Opcode 0x7 makes the next fetch come from its address word, so a program that jumps back to its start runs forever.
- R7: Opcode 0x8 pops every FIFO word until it pops one whose marker equals command bits 3:0. Each word it drops with a different marker sets status bit 14, unless command bit 15 is 1.
- R8: When an instruction completes, the nibble becomes (old AND NOT bits 23:20) OR bits 19:16. The nibble reads back in status bits 31:28.
- R9: An instruction with command bit 24 set sets status bit 11 when it completes. Status bit 27 reads 1 while the engine is fetching or executing.
- R10: Any other opcode sets status bit 18 and halts the engine, with bit 27 at 0 and no further fetches. The engine stays halted until the enables are cleared and set again.
- R11: Writing 1 to status bits 11, 14 or 18 (select 2) clears them. An event arriving in the same cycle wins over the clear.
- R12: `irq` is high exactly when some status bit among 11, 14 and 18 is set and the same bit is set in the mask register (select 3).
- R13: Clearing either enable bit stops all strobes in the next cycle and returns the engine to idle.
- R14: `dmem_sol` marks the first word written by a write whose command bit 27 is 1. `dmem_eol` marks the last word written by a write whose command bit 26 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start, 1 control, 2 status, 3 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | AW | Instruction fetch byte address |
| imem_ack | input | 1 | Fetch completes; `imem_data` valid |
| imem_data | input | 32 | Fetched instruction word |
| dmem_we | output | 1 | Data write request |
| dmem_addr | output | AW | Data write byte address |
| dmem_data | output | 32 | Data write word |
| dmem_be | output | 4 | Byte enables from the command |
| dmem_sol | output | 1 | First word of a start-of-line write |
| dmem_eol | output | 1 | Last word of an end-of-line write |
| dmem_ack | input | 1 | Data write accepted |
| fifo_valid | input | 1 | FIFO head is present |
| fifo_data | input | 32 | FIFO head word |
| fifo_mark | input | 4 | Marker code of the FIFO head |
| fifo_pop | output | 1 | Consume FIFO head |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets five corner cases:

- **Byte counts below one word.** A design that rounded such a count up would write a stray word.
- **Continued write after a prior write.** A design that reloaded the address word would restart the address sequence.
- **Sync that finds junk ahead of the marker.** A design that peeked at the head instead of draining it would hang, or would write the marker word as data, and the suppress bit would be ignored.
- **A loop closed by a jump and a stop issued mid-program.** A design that only changed state at instruction boundaries would keep popping or writing after the enables fall.
- **Mask, clear and undefined-opcode behaviour.** A design that resumed after an illegal opcode, or that confused the clear and set order of the progress nibble, would show the wrong status word.

// File: rtl/capdma_seq_pkg.sv
package capdma_seq_pkg;

    localparam int unsigned CW        = 32;
    localparam int unsigned CNT_W     = 12;
    localparam int unsigned WCNT_W    = CNT_W - 2;

    localparam logic [3:0] OPC_WR_ABS = 4'h1;
    localparam logic [3:0] OPC_SKIP   = 4'h2;
    localparam logic [3:0] OPC_WR_CUR = 4'h5;
    localparam logic [3:0] OPC_JUMP   = 4'h7;
    localparam logic [3:0] OPC_SYNC   = 4'h8;

    localparam int unsigned ST_IRQ_BIT    = 11;
    localparam int unsigned ST_RESYNC_BIT = 14;
    localparam int unsigned ST_OPERR_BIT  = 18;
    localparam int unsigned ST_RUN_BIT    = 27;
    localparam int unsigned ST_NIB_LSB    = 28;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_STAT  = 2'd2;
    localparam logic [1:0] SEL_MASK  = 2'd3;

    typedef enum logic [2:0] {
        K_WR_ABS,
        K_WR_CUR,
        K_SKIP,
        K_JUMP,
        K_SYNC,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic              sol;
        logic              eol;
        logic              irq;
        logic              nores;
        logic [3:0]        clrm;
        logic [3:0]        setm;
        logic [3:0]        be;
        logic [3:0]        mark;
        logic [WCNT_W-1:0] words;
    } dec_cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FCMD,
        S_FADR,
        S_EXEC,
        S_MOVE,
        S_SYNC,
        S_HALT
    } seq_state_e;

endpackage

// File: rtl/capdma_seq_decode.sv
module capdma_seq_decode
    import capdma_seq_pkg::*;
(
    input  logic [CW-1:0] cmd,
    output dec_cmd_t      dec
);

    logic unused_bits;
    assign unused_bits = ^{cmd[25], cmd[1:0]};

    always_comb begin
        dec       = '0;
        dec.sol   = cmd[27];
        dec.eol   = cmd[26];
        dec.irq   = cmd[24];
        dec.clrm  = cmd[23:20];
        dec.setm  = cmd[19:16];
        dec.be    = cmd[15:12];
        dec.nores = cmd[15];
        dec.mark  = cmd[3:0];
        dec.words = cmd[CNT_W-1:2];
        case (cmd[31:28])
            OPC_WR_ABS: dec.kind = K_WR_ABS;
            OPC_WR_CUR: dec.kind = K_WR_CUR;
            OPC_SKIP:   dec.kind = K_SKIP;
            OPC_JUMP:   dec.kind = K_JUMP;
            OPC_SYNC:   dec.kind = K_SYNC;
            default:    dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/capdma_seq_regs.sv
module capdma_seq_regs
    import capdma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          ev_irq,
    input  logic          ev_resync,
    input  logic          ev_operr,
    input  logic          running,
    input  logic [3:0]    nib,
    output logic [AW-1:0] start_addr,
    output logic          run,
    output logic          irq
);

    typedef struct packed {
        logic [AW-1:0] start;
        logic [1:0]    ctl;
        logic [2:0]    sticky;
        logic [2:0]    mask;
    } regs_t;

    regs_t q, d;
    logic [2:0] w1c, evs;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    function automatic logic [CW-1:0] flag_word(input logic [2:0] f);
        logic [CW-1:0] w;
        w                = '0;
        w[ST_IRQ_BIT]    = f[0];
        w[ST_RESYNC_BIT] = f[1];
        w[ST_OPERR_BIT]  = f[2];
        return w;
    endfunction

    always_comb begin
        d   = q;
        evs = {ev_operr, ev_resync, ev_irq};
        w1c = '0;
        if (reg_we) begin
            case (reg_sel)
                SEL_START: d.start = reg_wdata[AW-1:0];
                SEL_CTRL:  d.ctl   = reg_wdata[1:0];
                SEL_STAT:  w1c     = {reg_wdata[ST_OPERR_BIT], reg_wdata[ST_RESYNC_BIT],
                                      reg_wdata[ST_IRQ_BIT]};
                default:   d.mask  = {reg_wdata[ST_OPERR_BIT], reg_wdata[ST_RESYNC_BIT],
                                      reg_wdata[ST_IRQ_BIT]};
            endcase
        end
        d.sticky = (q.sticky & ~w1c) | evs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_sel)
            SEL_START: reg_rdata = CW'(q.start);
            SEL_CTRL:  reg_rdata = {{(CW-2){1'b0}}, q.ctl};
            SEL_STAT: begin
                reg_rdata                         = flag_word(q.sticky);
                reg_rdata[ST_RUN_BIT]             = running;
                reg_rdata[ST_NIB_LSB+3:ST_NIB_LSB] = nib;
            end
            default:   reg_rdata = flag_word(q.mask);
        endcase
    end

    assign start_addr = q.start;
    assign run        = &q.ctl;
    assign irq        = |(q.sticky & q.mask);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_STAT && reg_wdata[ST_IRQ_BIT] && !ev_irq)
        |=> (reg_rdata[ST_IRQ_BIT] == 1'b0 || reg_sel != SEL_STAT)); // R11
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_operr |=> q.sticky[2]); // R10
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mask == 3'b000) |-> !irq); // R12

endmodule

// File: rtl/capdma_seq_core.sv
module capdma_seq_core
    import capdma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] start_addr,
    output logic [CW-1:0] cmd_word,
    input  dec_cmd_t      dec,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_ack,
    input  logic [CW-1:0] imem_data,
    output logic          dmem_we,
    output logic [AW-1:0] dmem_addr,
    output logic [CW-1:0] dmem_data,
    output logic [3:0]    dmem_be,
    output logic          dmem_sol,
    output logic          dmem_eol,
    input  logic          dmem_ack,
    input  logic          fifo_valid,
    input  logic [CW-1:0] fifo_data,
    input  logic [3:0]    fifo_mark,
    output logic          fifo_pop,
    output logic          ev_irq,
    output logic          ev_resync,
    output logic          ev_operr,
    output logic          running,
    output logic [3:0]    nib
);

    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    typedef struct packed {
        seq_state_e        st;
        logic [AW-1:0]     pc;
        logic [CW-1:0]     cmd;
        logic [AW-1:0]     adr;
        logic [AW-1:0]     cur;
        logic [WCNT_W-1:0] left;
        logic              first;
        logic [3:0]        nib;
    } core_t;

    core_t q, d;
    logic  finish, step;

    always_comb begin
        d         = q;
        imem_req  = 1'b0;
        dmem_we   = 1'b0;
        fifo_pop  = 1'b0;
        ev_irq    = 1'b0;
        ev_resync = 1'b0;
        ev_operr  = 1'b0;
        finish    = 1'b0;
        step      = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (run) begin
                    d.st = S_FCMD;
                    d.pc = start_addr;
                end
            end
            S_FCMD: begin
                imem_req = 1'b1;
                if (imem_ack) begin
                    d.cmd = imem_data;
                    d.pc  = q.pc + WORD_STEP;
                    d.st  = S_FADR;
                end
            end
            S_FADR: begin
                imem_req = 1'b1;
                if (imem_ack) begin
                    d.adr = imem_data[AW-1:0];
                    d.pc  = q.pc + WORD_STEP;
                    d.st  = S_EXEC;
                end
            end
            S_EXEC: begin
                case (dec.kind)
                    K_JUMP: begin
                        d.pc   = q.adr;
                        finish = 1'b1;
                    end
                    K_WR_ABS, K_WR_CUR, K_SKIP: begin
                        if (dec.kind == K_WR_ABS) d.cur = q.adr;
                        d.left  = dec.words;
                        d.first = 1'b1;
                        if (dec.words == '0) finish = 1'b1;
                        else                 d.st   = S_MOVE;
                    end
                    K_SYNC: d.st = S_SYNC;
                    default: begin
                        ev_operr = 1'b1;
                        d.st     = S_HALT;
                    end
                endcase
            end
            S_MOVE: begin
                if (dec.kind == K_SKIP) begin
                    fifo_pop = fifo_valid;
                    step     = fifo_valid;
                end else begin
                    dmem_we  = fifo_valid;
                    step     = fifo_valid & dmem_ack;
                    fifo_pop = step;
                end
                if (step) begin
                    if (dec.kind != K_SKIP) d.cur = q.cur + WORD_STEP;
                    d.left  = q.left - 1'b1;
                    d.first = 1'b0;
                    if (q.left == WCNT_W'(1)) finish = 1'b1;
                end
            end
            S_SYNC: begin
                fifo_pop = fifo_valid;
                if (fifo_valid) begin
                    if (fifo_mark == dec.mark) finish    = 1'b1;
                    else if (!dec.nores)       ev_resync = 1'b1;
                end
            end
            default: ;
        endcase
        if (finish) begin
            d.st   = S_FCMD;
            d.nib  = (q.nib & ~dec.clrm) | dec.setm;
            ev_irq = dec.irq;
        end
        if (!run) begin
            d.st      = S_IDLE;
            d.nib     = q.nib;
            imem_req  = 1'b0;
            dmem_we   = 1'b0;
            fifo_pop  = 1'b0;
            ev_irq    = 1'b0;
            ev_resync = 1'b0;
            ev_operr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_word  = q.cmd;
    assign imem_addr = q.pc;
    assign dmem_addr = q.cur;
    assign dmem_data = fifo_data;
    assign dmem_be   = dec.be;
    assign dmem_sol  = dmem_we & q.first & dec.sol;
    assign dmem_eol  = dmem_we & (q.left == WCNT_W'(1)) & dec.eol;
    assign running   = (q.st != S_IDLE) && (q.st != S_HALT);
    assign nib       = q.nib;

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid); // R5
    AST_HALT_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_HALT) |-> !(imem_req || dmem_we || fifo_pop)); // R10
    AST_OPERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_operr |=> (q.st == S_HALT)); // R10
    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_MOVE && dmem_we && dmem_ack && q.left != WCNT_W'(1))
        |=> (dmem_addr == $past(dmem_addr) + WORD_STEP)); // R3
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.st == S_IDLE)); // R13
    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_req && dmem_we)); // R2

endmodule

// File: rtl/capdma_seq.sv
module capdma_seq
    import capdma_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_ack,
    input  logic [31:0]   imem_data,
    output logic          dmem_we,
    output logic [AW-1:0] dmem_addr,
    output logic [31:0]   dmem_data,
    output logic [3:0]    dmem_be,
    output logic          dmem_sol,
    output logic          dmem_eol,
    input  logic          dmem_ack,
    input  logic          fifo_valid,
    input  logic [31:0]   fifo_data,
    input  logic [3:0]    fifo_mark,
    output logic          fifo_pop,
    output logic          irq
);

    logic [AW-1:0] start_addr;
    logic          run, running;
    logic          ev_irq, ev_resync, ev_operr;
    logic [3:0]    nib;
    logic [CW-1:0] cmd_word;
    dec_cmd_t      dec;

    capdma_seq_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_irq(ev_irq), .ev_resync(ev_resync), .ev_operr(ev_operr),
        .running(running), .nib(nib),
        .start_addr(start_addr), .run(run), .irq(irq)
    );

    capdma_seq_decode u_dec (
        .cmd(cmd_word), .dec(dec)
    );

    capdma_seq_core #(.AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .start_addr(start_addr),
        .cmd_word(cmd_word), .dec(dec),
        .imem_req(imem_req), .imem_addr(imem_addr), .imem_ack(imem_ack), .imem_data(imem_data),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_data(dmem_data), .dmem_be(dmem_be),
        .dmem_sol(dmem_sol), .dmem_eol(dmem_eol), .dmem_ack(dmem_ack),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_mark(fifo_mark), .fifo_pop(fifo_pop),
        .ev_irq(ev_irq), .ev_resync(ev_resync), .ev_operr(ev_operr),
        .running(running), .nib(nib)
    );

endmodule

// File: tb/capdma_seq_bench.sv
`timescale 1ns/1ps
module capdma_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        imem_req, imem_ack;
    logic [31:0] imem_addr, imem_data;
    logic        dmem_we, dmem_ack, dmem_sol, dmem_eol;
    logic [31:0] dmem_addr, dmem_data;
    logic [3:0]  dmem_be;
    logic        fifo_valid, fifo_pop, irq;
    logic [31:0] fifo_data;
    logic [3:0]  fifo_mark;

    logic [31:0] prog [64];
    logic [31:0] fdat [32];
    logic [3:0]  fmrk [32];
    int          fifo_len = 0;
    int          fidx, wr_cnt, pop_cnt, sol_cnt, eol_cnt, fz_cnt, fetch_cnt, cyc;
    logic [31:0] wr_last, wr_first, wr_data, fetch_first;
    logic [3:0]  wr_be;
    logic        log_clr = 1'b0;
    logic        bp = 1'b0;
    logic        done = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    assign imem_ack   = imem_req;
    assign imem_data  = prog[imem_addr[7:2]];
    assign dmem_ack   = !(bp && cyc[0]);
    assign fifo_valid = fidx < fifo_len;
    assign fifo_data  = fdat[fidx[4:0]];
    assign fifo_mark  = fmrk[fidx[4:0]];

    capdma_seq u_capdma_seq (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .imem_req(imem_req), .imem_addr(imem_addr), .imem_ack(imem_ack), .imem_data(imem_data),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_data(dmem_data), .dmem_be(dmem_be),
        .dmem_sol(dmem_sol), .dmem_eol(dmem_eol), .dmem_ack(dmem_ack),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_mark(fifo_mark), .fifo_pop(fifo_pop),
        .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (log_clr || !rst_n) begin
            fidx <= 0; wr_cnt <= 0; pop_cnt <= 0; sol_cnt <= 0; eol_cnt <= 0;
            fz_cnt <= 0; fetch_cnt <= 0; wr_last <= '0; wr_first <= '0;
            wr_data <= '0; wr_be <= '0; fetch_first <= '0;
        end else begin
            if (fifo_pop) begin fidx <= fidx + 1; pop_cnt <= pop_cnt + 1; end
            if (dmem_we && dmem_ack) begin
                wr_cnt <= wr_cnt + 1; wr_last <= dmem_addr; wr_data <= dmem_data; wr_be <= dmem_be;
                if (wr_cnt == 0) wr_first <= dmem_addr;
                if (dmem_sol) sol_cnt <= sol_cnt + 1;
                if (dmem_eol) eol_cnt <= eol_cnt + 1;
            end
            if (imem_req && imem_ack) begin
                fetch_cnt <= fetch_cnt + 1;
                if (fetch_cnt == 0) fetch_first <= imem_addr;
                if (imem_addr == 32'h0) fz_cnt <= fz_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic sol, input logic eol,
                                       input logic irqf, input logic [3:0] clr, input logic [3:0] set,
                                       input logic [3:0] be, input logic [11:0] cnt);
        return {op, sol, eol, 1'b0, irqf, clr, set, be, cnt};
    endfunction

    task automatic reg_wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk); reg_sel = s; #1; v = reg_rdata;
    endtask

    task automatic clr_logs();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = '0;
    endtask

    task automatic put_fifo(input int i, input logic [3:0] m, input logic [31:0] v);
        fmrk[i] = m; fdat[i] = v;
    endtask

    task automatic wait_halt(input string req);
        logic [31:0] s;
        bit          ok;
        ok = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            reg_rd(2'd2, s);
            if (!s[27]) begin ok = 1'b1; break; end
        end
        if (!ok) chk(req, 32'h1, 32'h0);
    endtask

    task automatic prepare();
        reg_wr(2'd1, 32'h0);
        reg_wr(2'd2, 32'hFFFF_FFFF);
        clear_prog();
        fifo_len = 0;
        clr_logs();
    endtask

    localparam logic [99:0] VEC [6] = '{
        {4'h1, 12'd16, 32'h0000_1000, 4'h2, 8'd4,  32'h0000_100C, 8'd5},
        {4'h1, 12'd4,  32'h0000_2000, 4'h4, 8'd1,  32'h0000_2000, 8'd2},
        {4'h2, 12'd12, 32'h0000_0000, 4'h6, 8'd0,  32'h0000_0000, 8'd4},
        {4'h1, 12'd3,  32'h0000_3000, 4'h1, 8'd0,  32'h0000_0000, 8'd1},
        {4'h1, 12'd40, 32'h0000_3000, 4'hA, 8'd10, 32'h0000_3024, 8'd11},
        {4'h1, 12'd64, 32'h0000_4000, 4'h3, 8'd16, 32'h0000_403C, 8'd17}
    };

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int          fcnt;
        clear_prog();
        for (int i = 0; i < 32; i++) put_fifo(i, 4'h0, '0);
        repeat (4) @(negedge clk);
        // R1: reset state
        reg_rd(2'd2, s);   chk("R1 status", s, 32'h0);
        reg_rd(2'd1, s);   chk("R1 control", s, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 strobes", {29'b0, imem_req, dmem_we, fifo_pop}, 32'h0);
        rst_n = 1'b1;
        reg_wr(2'd0, 32'h0);

        // vector table: R3 R5 R8 R9 R10 R14
        for (int r = 0; r < 6; r++) begin
            logic [99:0] v;
            v = VEC[r];
            prepare();
            bp = r[0];
            prog[0] = mk(4'h8, 0, 0, 0, 4'h0, 4'h0, 4'h0, 12'h006);
            prog[2] = mk(v[99:96], 1, 1, 1, 4'hF, v[51:48], 4'hB, v[95:84]);
            prog[3] = v[83:52];
            put_fifo(0, 4'h6, 32'h0);
            for (int k = 1; k < 17; k++) put_fifo(k, 4'h0, 32'hA000 + k);
            fifo_len = 17;
            reg_wr(2'd1, 32'h3);
            wait_halt("R10 halt");
            chk("R3 write count", wr_cnt, {24'h0, v[47:40]});
            chk("R5 pops", pop_cnt, {24'h0, v[7:0]});
            if (v[47:40] != 0) begin
                chk("R3 last address", wr_last, v[39:8]);
                chk("R3 byte enables", {28'h0, wr_be}, 32'hB);
            end
            chk("R14 sol", sol_cnt, (v[47:40] != 0) ? 1 : 0);
            chk("R14 eol", eol_cnt, (v[47:40] != 0) ? 1 : 0);
            reg_rd(2'd2, s);
            chk("R8 R9 R10 status", s, {v[51:48], 28'h0} | 32'h0004_0800);
            fcnt = fetch_cnt;
            repeat (10) @(negedge clk);
            chk("R10 no refetch", fetch_cnt, fcnt);
        end
        bp = 1'b0;

        // R2 R4: start address and continued write
        prepare();
        reg_wr(2'd0, 32'h20);
        prog[8]  = mk(4'h1, 0, 0, 0, 0, 0, 4'hF, 12'd8);  prog[9]  = 32'h5000;
        prog[10] = mk(4'h5, 0, 0, 0, 0, 0, 4'hF, 12'd8);  prog[11] = 32'hDEAD_0000;
        for (int k = 0; k < 4; k++) put_fifo(k, 4'h0, 32'hC0 + k);
        fifo_len = 4;
        reg_wr(2'd1, 32'h3);
        wait_halt("R2 halt");
        chk("R2 first fetch", fetch_first, 32'h20);
        chk("R2 fetch count", fetch_cnt, 6);
        chk("R4 write count", wr_cnt, 4);
        chk("R4 first address", wr_first, 32'h5000);
        chk("R4 last address", wr_last, 32'h500C);
        chk("R4 last data", wr_data, 32'hC3);

        // R6: jump loop, then R13 stop
        prepare();
        reg_wr(2'd0, 32'h0);
        prog[0] = mk(4'h7, 0, 0, 0, 0, 0, 0, 0);        prog[1] = 32'h10;
        prog[4] = mk(4'h1, 0, 0, 0, 0, 0, 4'hF, 12'd4); prog[5] = 32'h6000;
        prog[6] = mk(4'h7, 0, 0, 0, 0, 0, 0, 0);        prog[7] = 32'h0;
        for (int k = 0; k < 3; k++) put_fifo(k, 4'h0, 32'h60 + k);
        fifo_len = 3;
        reg_wr(2'd1, 32'h3);
        repeat (80) @(negedge clk);
        chk("R6 loop writes", wr_cnt, 3);
        chk("R6 loop address", wr_last, 32'h6000);
        chk("R6 restarts", fz_cnt, 4);
        reg_rd(2'd2, s);   chk("R9 running", {31'b0, s[27]}, 32'h1);
        reg_wr(2'd1, 32'h1);
        @(negedge clk);
        chk("R13 strobes", {30'b0, imem_req, dmem_we}, 32'h0);
        put_fifo(3, 4'h0, 32'h99);
        fifo_len = 4;
        repeat (8) @(negedge clk);
        chk("R13 no write", wr_cnt, 3);
        chk("R13 no pop", pop_cnt, 3);
        reg_rd(2'd2, s);   chk("R13 stopped", {31'b0, s[27]}, 32'h0);

        // R7: sync drains junk, with and without suppression
        for (int pass = 0; pass < 2; pass++) begin
            prepare();
            prog[0] = mk(4'h8, 0, 0, 0, 0, 0, (pass == 1) ? 4'h8 : 4'h0, 12'h006);
            prog[2] = mk(4'h1, 0, 0, 0, 0, 0, 4'hF, 12'd4); prog[3] = 32'h7000;
            put_fifo(0, 4'h0, 32'h111); put_fifo(1, 4'hC, 32'h222);
            put_fifo(2, 4'h6, 32'h0);   put_fifo(3, 4'h0, 32'hBEEF);
            fifo_len = 4;
            reg_wr(2'd1, 32'h3);
            wait_halt("R7 halt");
            reg_rd(2'd2, s);
            chk("R7 resync flag", {31'b0, s[14]}, (pass == 1) ? 32'h0 : 32'h1);
            chk("R7 data after marker", wr_data, 32'hBEEF);
            chk("R7 pops", pop_cnt, 4);
        end

        // R8: clear-then-set order
        prepare();
        prog[0] = mk(4'h8, 0, 0, 0, 4'hF, 4'hC, 0, 12'h00C);
        prog[2] = mk(4'h1, 0, 0, 0, 4'h4, 4'h1, 0, 12'd0);
        put_fifo(0, 4'hC, 32'h0);
        fifo_len = 1;
        reg_wr(2'd1, 32'h3);
        wait_halt("R8 halt");
        reg_rd(2'd2, s);
        chk("R8 nibble order", s, 32'h9004_0000);

        // R11 R12: mask and write-one-to-clear
        reg_wr(2'd3, 32'h0);
        chk("R12 masked off", {31'b0, irq}, 32'h0);
        reg_wr(2'd3, 32'h0000_0800);
        chk("R12 other bit", {31'b0, irq}, 32'h0);
        reg_wr(2'd3, 32'h0004_0000);
        chk("R12 unmasked", {31'b0, irq}, 32'h1);
        reg_wr(2'd2, 32'h0000_0800);
        reg_rd(2'd2, s);
        chk("R11 untouched bit", {31'b0, s[18]}, 32'h1);
        reg_wr(2'd2, 32'h0004_0000);
        reg_rd(2'd2, s);
        chk("R11 cleared", {31'b0, s[18]}, 32'h0);
        chk("R12 after clear", {31'b0, irq}, 32'h0);

        // R10: re-enable after halt runs again
        reg_wr(2'd1, 32'h0);
        clr_logs();
        reg_wr(2'd1, 32'h3);
        wait_halt("R10 rerun");
        chk("R10 restart fetch", fetch_first, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule